// File: doc/BRIEF.md
# Linked-List Descriptor Sequencer

This block is the control core of one DMA channel that works through a chain of transfer descriptors kept in system memory. Software stores a first descriptor pointer and then sets the channel enable. The block reads the five-word descriptor at that pointer through a read port that allows one request at a time, and it loads its channel registers from those words. It then starts an external data mover with the source address, destination address, block size and second control word. When the mover reports completion with a transferred count, the block writes one updated copy of the first control word back to its original location and raises a per-buffer pulse.

After that write the block follows the next-descriptor pointer at once. It does not wait for software to service the buffer interrupt. The chain stops after the buffer whose next pointer is zero, or whose second control word has its stop bit set. At that point the enable drops and a chain-complete pulse fires. Both events also leave sticky status flags, and a status read clears them. Clearing the enable in the middle of a chain lets the memory access in progress finish, and the block then returns to idle without a write-back.

Top module: `lldma_seq`

## Requirements
- R1: After reset the block is idle (busy=0), the enable is 0, no read, write or mover start is requested, and both status flags are 0.
- R2: After software loads a pointer with ptr_wr while idle and pulses ena_set, ch_en rises, and the first descriptor read is issued to exactly that pointer.
- R3: A descriptor is read as five single requests to base+0x0, +0x4, +0x8, +0xC and +0x10, in that order. Each request waits for its response before the next is issued, holds its address until rd_req_ready, and never overlaps a write.
- R4: After the fifth word arrives, mv_start pulses for one cycle. At that pulse mv_src is word 0, mv_dst is word 1, mv_len is bits [BTW-1:0] of word 3 (control A) and mv_ctrlb is word 4.
- R5: After mv_done, exactly one write is issued per buffer, to base+0xC. Its data is control A with bits [BTW-1:0] replaced by mv_count and bit DONE_POS (31) set, all other bits unchanged. No other descriptor word is written.
- R6: irq_buf pulses for one cycle when each write-back is accepted, once per buffer.
- R7: When a write-back is accepted and the chain goes on, the first read of the next descriptor is requested in the very next cycle, at the address held in word 2. No status read is needed.
- R8: The buffer whose word 2 is zero, or whose word 4 has bit STOP_POS (0) set, is the last. After its write-back the block goes idle, clears ch_en, pulses irq_chain once and issues no further reads.
- R9: stat_buf and stat_chain are set by their pulses and stay set until stat_rd, which clears them on the following edge.
- R10: If ena_clr arrives during a descriptor fetch, the read in flight receives its response and no further read, mover start or write follows. The block goes idle with no chain-complete.
- R11: If ena_clr arrives while the mover is busy, the block waits for mv_done and then goes idle with no write-back and no irq_buf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ena_set | input | 1 | Software write of 1 to the channel enable |
| ena_clr | input | 1 | Software clear of the channel enable |
| ptr_wr | input | 1 | Load the first descriptor pointer (idle only) |
| ptr_wdata | input | AW | First descriptor pointer |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| ch_en | output | 1 | Channel enable state |
| busy | output | 1 | Engine is walking a chain |
| stat_buf | output | 1 | Sticky buffer-complete flag |
| stat_chain | output | 1 | Sticky chain-complete flag |
| irq_buf | output | 1 | Buffer-complete pulse |
| irq_chain | output | 1 | Chain-complete pulse |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DW | Read data |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | DW | Write-back control word |
| mv_start | output | 1 | Start pulse to the data mover |
| mv_src | output | DW | Source address for the buffer |
| mv_dst | output | DW | Destination address for the buffer |
| mv_len | output | BTW | Block size for the buffer |
| mv_ctrlb | output | DW | Second control word for the buffer |
| mv_done | input | 1 | Mover completion pulse |
| mv_count | input | BTW | Amount transferred, reported at mv_done |

## Verification
A wrong word index or base register shows up on the first descriptor as a read address out of order, or as a mover start with fields taken from the wrong words. An error in the base register after a chain step shows up only on the second descriptor, so chains of one to four buffers are swept. A wrong end-of-chain decision shows within one cycle of the last write-back: an extra read request appears, or ch_en and irq_chain are wrong. A write-back merge error is visible in the one write of each buffer. The abort paths are checked by counting reads, responses, starts and writes after the block goes idle.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
   localparam int unsigned LLD_WORDS   = 5;
   localparam int unsigned LLD_STEP    = 4;
   localparam int unsigned LLD_IX_SRC  = 0;
   localparam int unsigned LLD_IX_DST  = 1;
   localparam int unsigned LLD_IX_NEXT = 2;
   localparam int unsigned LLD_IX_CTLA = 3;
   localparam int unsigned LLD_IX_CTLB = 4;
   localparam int unsigned LLD_IXW     = $clog2(LLD_WORDS);

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RREQ  = 3'd1,
      ST_RRSP  = 3'd2,
      ST_START = 3'd3,
      ST_WAIT  = 3'd4,
      ST_WB    = 3'd5
   } lld_state_e;
endpackage

// File: rtl/lldma_desc_regs.sv
module lldma_desc_regs
   import lldma_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned BTW      = 16,
   parameter int unsigned DONE_POS = 31
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_en,
   input  logic [LLD_IXW-1:0]         ld_idx,
   input  logic [DW-1:0]              ld_data,
   input  logic                       cnt_ld,
   input  logic [BTW-1:0]             cnt_in,
   output logic [LLD_WORDS-1:0][DW-1:0] words,
   output logic [DW-1:0]              wb_data
);
   logic [BTW-1:0] cnt_q;

   for (genvar g = 0; g < LLD_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[g] <= '0;
         end else if (ld_en && (ld_idx == LLD_IXW'(g))) begin
            words[g] <= ld_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_ld) begin
         cnt_q <= cnt_in;
      end
   end

   always_comb begin
      wb_data           = words[LLD_IX_CTLA];
      wb_data[BTW-1:0]  = cnt_q;
      wb_data[DONE_POS] = 1'b1;
   end
endmodule

// File: rtl/lldma_status.sv
module lldma_status (
   input  logic clk,
   input  logic rst_n,
   input  logic buf_evt,
   input  logic chain_evt,
   input  logic rd_clr,
   output logic flag_buf,
   output logic flag_chain
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_buf   <= 1'b0;
         flag_chain <= 1'b0;
      end else begin
         flag_buf   <= (flag_buf & ~rd_clr) | buf_evt;
         flag_chain <= (flag_chain & ~rd_clr) | chain_evt;
      end
   end
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
   import lldma_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ena_set,
   input  logic               ena_clr,
   input  logic               ptr_wr,
   input  logic [AW-1:0]      ptr_wdata,
   output logic               ch_en,
   output logic               busy,
   output logic               rd_req_valid,
   input  logic               rd_req_ready,
   output logic [AW-1:0]      rd_req_addr,
   input  logic               rd_rsp_valid,
   input  logic [AW-1:0]      rsp_ptr,
   output logic               ld_en,
   output logic [LLD_IXW-1:0] ld_idx,
   input  logic               stop_hint,
   output logic               wr_valid,
   input  logic               wr_ready,
   output logic [AW-1:0]      wr_addr,
   output logic               mv_start,
   input  logic               mv_done,
   output logic               buf_evt,
   output logic               chain_evt
);
   localparam logic [AW-1:0]      CTLA_OFS = AW'(LLD_IX_CTLA * LLD_STEP);
   localparam logic [LLD_IXW-1:0] IX_LAST  = LLD_IXW'(LLD_WORDS - 1);
   localparam logic [LLD_IXW-1:0] IX_NEXT  = LLD_IXW'(LLD_IX_NEXT);

   lld_state_e          state;
   logic [LLD_IXW-1:0]  idx;
   logic [AW-1:0]       base;
   logic [AW-1:0]       dscr;
   logic                en_q;
   logic                last_buf;

   assign last_buf     = (dscr == '0) | stop_hint;
   assign busy         = (state != ST_IDLE);
   assign rd_req_valid = (state == ST_RREQ);
   assign rd_req_addr  = base + AW'({idx, 2'b00});
   assign wr_valid     = (state == ST_WB);
   assign wr_addr      = base + CTLA_OFS;
   assign mv_start     = (state == ST_START);
   assign ld_en        = (state == ST_RRSP) && rd_rsp_valid;
   assign ld_idx       = idx;
   assign buf_evt      = (state == ST_WB) && wr_ready;
   assign chain_evt    = buf_evt && last_buf && en_q;
   assign ch_en        = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= (en_q | ena_set) & ~ena_clr & ~chain_evt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         base  <= '0;
         dscr  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (ptr_wr) begin
                  dscr <= ptr_wdata;
               end
               if (en_q) begin
                  base  <= dscr;
                  idx   <= '0;
                  state <= ST_RREQ;
               end
            end
            ST_RREQ: begin
               if (rd_req_ready) begin
                  state <= ST_RRSP;
               end
            end
            ST_RRSP: begin
               if (rd_rsp_valid) begin
                  if (idx == IX_NEXT) begin
                     dscr <= rsp_ptr;
                  end
                  if (!en_q) begin
                     state <= ST_IDLE;
                  end else if (idx == IX_LAST) begin
                     state <= ST_START;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_RREQ;
                  end
               end
            end
            ST_START: begin
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mv_done) begin
                  state <= en_q ? ST_WB : ST_IDLE;
               end
            end
            ST_WB: begin
               if (wr_ready) begin
                  if (last_buf || !en_q) begin
                     state <= ST_IDLE;
                  end else begin
                     base  <= dscr;
                     idx   <= '0;
                     state <= ST_RREQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
   import lldma_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned BTW      = 16,
   parameter int unsigned DONE_POS = 31,
   parameter bit          USE_STOP = 1'b1,
   parameter int unsigned STOP_POS = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ena_set,
   input  logic            ena_clr,
   input  logic            ptr_wr,
   input  logic [AW-1:0]   ptr_wdata,
   input  logic            stat_rd,
   output logic            ch_en,
   output logic            busy,
   output logic            stat_buf,
   output logic            stat_chain,
   output logic            irq_buf,
   output logic            irq_chain,
   output logic            rd_req_valid,
   input  logic            rd_req_ready,
   output logic [AW-1:0]   rd_req_addr,
   input  logic            rd_rsp_valid,
   input  logic [DW-1:0]   rd_rsp_data,
   output logic            wr_valid,
   input  logic            wr_ready,
   output logic [AW-1:0]   wr_addr,
   output logic [DW-1:0]   wr_data,
   output logic            mv_start,
   output logic [DW-1:0]   mv_src,
   output logic [DW-1:0]   mv_dst,
   output logic [BTW-1:0]  mv_len,
   output logic [DW-1:0]   mv_ctrlb,
   input  logic            mv_done,
   input  logic [BTW-1:0]  mv_count
);
   if (BTW == 0 || BTW > DONE_POS) begin : g_bad_btw
      initial $fatal(1, "lldma_seq: BTW must be 1..DONE_POS");
   end
   if (DONE_POS >= DW) begin : g_bad_done
      initial $fatal(1, "lldma_seq: DONE_POS outside the word");
   end
   if (DW < AW || AW <= LLD_IXW + 2) begin : g_bad_aw
      initial $fatal(1, "lldma_seq: AW must fit in DW and exceed the offset width");
   end
   if (STOP_POS >= DW) begin : g_bad_stop
      initial $fatal(1, "lldma_seq: STOP_POS outside the word");
   end

   logic [LLD_WORDS-1:0][DW-1:0] words;
   logic                         ld_en;
   logic [LLD_IXW-1:0]           ld_idx;
   logic                         stop_hint;
   logic                         buf_evt;
   logic                         chain_evt;

   if (USE_STOP) begin : g_stop
      assign stop_hint = words[LLD_IX_CTLB][STOP_POS];
   end else begin : g_nostop
      assign stop_hint = 1'b0;
   end

   lldma_ctrl #(.AW(AW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .ena_set      (ena_set),
      .ena_clr      (ena_clr),
      .ptr_wr       (ptr_wr),
      .ptr_wdata    (ptr_wdata),
      .ch_en        (ch_en),
      .busy         (busy),
      .rd_req_valid (rd_req_valid),
      .rd_req_ready (rd_req_ready),
      .rd_req_addr  (rd_req_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rsp_ptr      (rd_rsp_data[AW-1:0]),
      .ld_en        (ld_en),
      .ld_idx       (ld_idx),
      .stop_hint    (stop_hint),
      .wr_valid     (wr_valid),
      .wr_ready     (wr_ready),
      .wr_addr      (wr_addr),
      .mv_start     (mv_start),
      .mv_done      (mv_done),
      .buf_evt      (buf_evt),
      .chain_evt    (chain_evt)
   );

   lldma_desc_regs #(.DW(DW), .BTW(BTW), .DONE_POS(DONE_POS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_idx  (ld_idx),
      .ld_data (rd_rsp_data),
      .cnt_ld  (mv_done),
      .cnt_in  (mv_count),
      .words   (words),
      .wb_data (wr_data)
   );

   lldma_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .buf_evt    (buf_evt),
      .chain_evt  (chain_evt),
      .rd_clr     (stat_rd),
      .flag_buf   (stat_buf),
      .flag_chain (stat_chain)
   );

   assign irq_buf   = buf_evt;
   assign irq_chain = chain_evt;
   assign mv_src    = words[LLD_IX_SRC];
   assign mv_dst    = words[LLD_IX_DST];
   assign mv_len    = words[LLD_IX_CTLA][BTW-1:0];
   assign mv_ctrlb  = words[LLD_IX_CTLB];
endmodule

// File: rtl/lldma_seq_chk.sv
module lldma_seq_chk #(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned DONE_POS = 31
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          ch_en,
   input logic          stat_buf,
   input logic          irq_buf,
   input logic          irq_chain,
   input logic          rd_req_valid,
   input logic          rd_req_ready,
   input logic [AW-1:0] rd_req_addr,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          mv_start
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req_valid && !wr_valid && !mv_start));

   assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

   assert_rd_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

   assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req_valid && wr_valid));

   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start |=> !mv_start);

   assert_wb_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> wr_data[DONE_POS]);

   assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   assert_irq_at_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_buf |-> (wr_valid && wr_ready));

   assert_chain_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_chain |=> (!ch_en && !busy));

   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_buf |=> stat_buf);
endmodule

bind lldma_seq lldma_seq_chk #(.AW(AW), .DW(DW), .DONE_POS(DONE_POS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .ch_en        (ch_en),
   .stat_buf     (stat_buf),
   .irq_buf      (irq_buf),
   .irq_chain    (irq_chain),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .rd_req_addr  (rd_req_addr),
   .wr_valid     (wr_valid),
   .wr_ready     (wr_ready),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .mv_start     (mv_start)
);

// File: tb/lldma_seq_tb.sv
module lldma_seq_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ena_set = 1'b0, ena_clr = 1'b0, ptr_wr = 1'b0, stat_rd = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        ch_en, busy, stat_buf, stat_chain, irq_buf, irq_chain;
   logic        rd_req_valid, rd_req_ready, rd_rsp_valid, wr_valid, wr_ready;
   logic [31:0] rd_req_addr, rd_rsp_data, wr_addr, wr_data;
   logic        mv_start, mv_done;
   logic [31:0] mv_src, mv_dst, mv_ctrlb;
   logic [15:0] mv_len, mv_count;

   always #(CLK_P/2) clk = ~clk;

   lldma_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ena_set(ena_set), .ena_clr(ena_clr),
      .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .stat_rd(stat_rd),
      .ch_en(ch_en), .busy(busy), .stat_buf(stat_buf), .stat_chain(stat_chain),
      .irq_buf(irq_buf), .irq_chain(irq_chain),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
      .mv_ctrlb(mv_ctrlb), .mv_done(mv_done), .mv_count(mv_count)
   );

   // memory image, written only by the stimulus process
   logic [31:0] mem [0:255];

   // models and logs
   int          cyc = 0;
   logic [7:0]  raddr;
   int          rsp_wait = 0;
   int          mvd = 0;
   logic        rv_prev = 1'b0;
   int nrd = 0, nrsp = 0, nst = 0, nwr = 0, nbirq = 0, ncirq = 0, nrise = 0;
   logic [31:0] rd_log [0:63];
   logic [31:0] st_src [0:15], st_dst [0:15], st_len [0:15], st_cb [0:15];
   logic [31:0] wr_alog [0:15], wr_dlog [0:15];
   int          wr_cyc [0:15];
   int          rise_cyc [0:63];

   always @(posedge clk) begin
      cyc          <= cyc + 1;
      rd_req_ready <= ((cyc * 7) % 5) != 2;
      wr_ready     <= (cyc % 3) != 1;
      rd_rsp_valid <= 1'b0;
      mv_done      <= 1'b0;
      rv_prev      <= rd_req_valid;
      if (rsp_wait > 0) begin
         rsp_wait <= rsp_wait - 1;
         if (rsp_wait == 1) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= mem[raddr];
            nrsp         <= nrsp + 1;
         end
      end
      if (rd_req_valid && !rv_prev) begin
         rise_cyc[nrise % 64] <= cyc;
         nrise <= nrise + 1;
      end
      if (rd_req_valid && rd_req_ready) begin
         raddr            <= rd_req_addr[9:2];
         rsp_wait         <= 1 + (cyc % 2);
         rd_log[nrd % 64] <= rd_req_addr;
         nrd              <= nrd + 1;
      end
      if (wr_valid && wr_ready) begin
         wr_alog[nwr % 16] <= wr_addr;
         wr_dlog[nwr % 16] <= wr_data;
         wr_cyc[nwr % 16]  <= cyc;
         nwr               <= nwr + 1;
      end
      if (irq_buf)   nbirq <= nbirq + 1;
      if (irq_chain) ncirq <= ncirq + 1;
      if (mv_start) begin
         st_src[nst % 16] <= mv_src;
         st_dst[nst % 16] <= mv_dst;
         st_len[nst % 16] <= {16'h0, mv_len};
         st_cb[nst % 16]  <= mv_ctrlb;
         nst              <= nst + 1;
         mvd              <= (int'(mv_len) % 4) + 4;
         mv_count         <= 16'(mv_len * 3 + 1);
      end else if (mvd > 0) begin
         mvd <= mvd - 1;
         if (mvd == 1) mv_done <= 1'b1;
      end
   end

   int  nchk = 0, nerr = 0;
   bit  fin = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dbase(input int i);
      return 32'h40 + 32'(i) * 32'h20;
   endfunction

   function automatic logic [31:0] ctla_of(input int i, input int n);
      return 32'h0A5C_0000 | 32'((i * 37 + n * 5 + 3) & 16'hFFFF);
   endfunction

   // build a chain of n descriptors; stop_mode ends it by control B bit 0
   task automatic build(input int n, input bit stop_mode);
      for (int i = 0; i < n; i++) begin
         int w = int'(dbase(i) >> 2);
         mem[w+0] = 32'h1000_0000 + 32'(i) * 32'h100 + 32'(n);
         mem[w+1] = 32'h2000_0000 + 32'(i) * 32'h300 + 32'(n);
         mem[w+2] = (i == n - 1) ? (stop_mode ? 32'h3C0 : 32'h0) : dbase(i + 1);
         mem[w+3] = ctla_of(i, n);
         mem[w+4] = 32'h0000_1230 | (32'(i) << 4) | {31'h0, (stop_mode && i == n - 1)};
      end
   endtask

   task automatic pulse_stat_rd();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic kick(input logic [31:0] p);
      @(negedge clk); ptr_wr = 1'b1; ptr_wdata = p;
      @(negedge clk); ptr_wr = 1'b0; ena_set = 1'b1;
      @(negedge clk); ena_set = 1'b0;
   endtask

   task automatic wait_busy();
      for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_chain(input int n, input bit stop_mode);
      int s_rd, s_st, s_wr, s_b, s_c, s_rise;
      string t;
      build(n, stop_mode);
      pulse_stat_rd();
      s_rd = nrd; s_st = nst; s_wr = nwr; s_b = nbirq; s_c = ncirq; s_rise = nrise;
      kick(dbase(0));
      check($sformatf("R2 ch_en after enable n=%0d", n), {31'h0, ch_en | busy}, 32'h1);
      wait_busy();
      wait_idle();
      t = $sformatf("n=%0d stop=%0d", n, stop_mode);
      check({"R3 read count ", t}, nrd - s_rd, 5 * n);
      for (int j = 0; j < 5 * n; j++)
         check($sformatf("R3 R2 read %0d %s", j, t), rd_log[(s_rd + j) % 64],
               dbase(j / 5) + 32'(4 * (j % 5)));
      check({"R4 start count ", t}, nst - s_st, n);
      for (int i = 0; i < n; i++) begin
         int w = int'(dbase(i) >> 2);
         logic [31:0] cnt = 32'((ctla_of(i, n) * 3 + 1) & 32'hFFFF);
         check($sformatf("R4 src %0d %s", i, t), st_src[(s_st + i) % 16], mem[w+0]);
         check($sformatf("R4 dst %0d %s", i, t), st_dst[(s_st + i) % 16], mem[w+1]);
         check($sformatf("R4 len %0d %s", i, t), st_len[(s_st + i) % 16], mem[w+3] & 32'hFFFF);
         check($sformatf("R4 ctrlb %0d %s", i, t), st_cb[(s_st + i) % 16], mem[w+4]);
         check($sformatf("R5 wb addr %0d %s", i, t), wr_alog[(s_wr + i) % 16], dbase(i) + 32'hC);
         check($sformatf("R5 wb data %0d %s", i, t), wr_dlog[(s_wr + i) % 16],
               (mem[w+3] & 32'hFFFF_0000) | cnt | 32'h8000_0000);
         if (i < n - 1)
            check($sformatf("R7 next fetch gap %0d %s", i, t),
                  32'(rise_cyc[(s_rise + 5 * (i + 1)) % 64]), 32'(wr_cyc[(s_wr + i) % 16] + 1));
      end
      check({"R5 write count ", t}, nwr - s_wr, n);
      check({"R6 irq_buf count ", t}, nbirq - s_b, n);
      check({"R8 irq_chain count ", t}, ncirq - s_c, 1);
      check({"R8 ch_en cleared ", t}, {31'h0, ch_en}, 32'h0);
      check({"R8 busy low ", t}, {31'h0, busy}, 32'h0);
      check({"R9 stat_buf set ", t}, {31'h0, stat_buf}, 32'h1);
      check({"R9 stat_chain set ", t}, {31'h0, stat_chain}, 32'h1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      repeat (3) @(negedge clk);
      check("R1 busy at reset", {31'h0, busy}, 32'h0);
      check("R1 ch_en at reset", {31'h0, ch_en}, 32'h0);
      check("R1 rd_req_valid at reset", {31'h0, rd_req_valid}, 32'h0);
      check("R1 wr_valid at reset", {31'h0, wr_valid}, 32'h0);
      check("R1 status at reset", {30'h0, stat_buf, stat_chain}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after release", {29'h0, busy, mv_start, rd_req_valid}, 32'h0);

      for (int n = 1; n <= 4; n++) begin
         run_chain(n, 1'b0);
         run_chain(n, 1'b1);
      end

      // R9 clear on read
      pulse_stat_rd();
      @(negedge clk);
      check("R9 stat_buf cleared by read", {31'h0, stat_buf}, 32'h0);
      check("R9 stat_chain cleared by read", {31'h0, stat_chain}, 32'h0);

      // R10 disable during fetch
      begin
         int s_rd, s_st, s_wr, s_c;
         build(3, 1'b0);
         s_rd = nrd; s_st = nst; s_wr = nwr; s_c = ncirq;
         kick(dbase(0));
         for (int k = 0; k < 200 && (nrd - s_rd) < 2; k++) @(negedge clk);
         ena_clr = 1'b1; @(negedge clk); ena_clr = 1'b0;
         wait_idle();
         repeat (5) @(negedge clk);
         check("R10 reads stop after current", {31'h0, ((nrd - s_rd) >= 2) && ((nrd - s_rd) <= 3)}, 32'h1);
         check("R10 read in flight answered", nrsp - nrd, 0);
         check("R10 no mover start", nst - s_st, 0);
         check("R10 no write-back", nwr - s_wr, 0);
         check("R10 no chain complete", {31'h0, stat_chain}, 32'h0);
         check("R10 idle and disabled", {30'h0, busy, ch_en}, 32'h0);
      end

      // R11 disable while the mover is busy
      begin
         int s_rd, s_st, s_wr, s_b;
         build(2, 1'b0);
         pulse_stat_rd();
         s_rd = nrd; s_st = nst; s_wr = nwr; s_b = nbirq;
         kick(dbase(0));
         for (int k = 0; k < 400 && (nst - s_st) < 1; k++) @(negedge clk);
         ena_clr = 1'b1; @(negedge clk); ena_clr = 1'b0;
         check("R11 still busy until mover done", {31'h0, busy}, 32'h1);
         wait_idle();
         repeat (5) @(negedge clk);
         check("R11 one start", nst - s_st, 1);
         check("R11 five reads", nrd - s_rd, 5);
         check("R11 no write-back", nwr - s_wr, 0);
         check("R11 no irq_buf", nbirq - s_b, 0);
         check("R11 status flags clear", {30'h0, stat_buf, stat_chain}, 32'h0);
         check("R11 idle", {31'h0, busy}, 32'h0);
      end

      fin = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(CLK_P * 190000);
      if (!fin) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule